// File: doc/BRIEF.md
# SPI Master Transfer Engine

This block runs the master side of a four-wire serial peripheral link. A host places a word in a one-entry transmit buffer. The engine drops the active-low chip select, toggles the serial clock for an 8-bit or 16-bit frame, shifts the word out on the data-out line and collects a word from the data-in line. When the frame is over, the received word is placed on `rx_data` and a sticky completion flag is raised.

Clock polarity, clock phase, frame width and bit order are set per frame. The serial clock comes from an internal divider controlled by two 3-bit fields, `pre_div` and `exp_div`. If the host refills the buffer while a frame is in flight, the next frame follows straight on and chip select stays low between the two. A refill while a word is already waiting is dropped and raises a collision flag.

Top module: `spi_xfer_master`

## Requirements
- R1: One half period of the serial clock is H = (pre_div+1)·2^exp_div module clocks. The full clock divisor is therefore (pre_div+1)·2^(exp_div+1). The serial clock changes level only at half-period boundaries.
- R2: With `wide`=1 a frame carries 16 bits over 32 clock edges. With `wide`=0 it carries bits [7:0] of the word over 16 edges, and `rx_data[15:8]` reads 0.
- R3: With `lsb_first`=0 bit N-1 travels first. With `lsb_first`=1 bit 0 travels first. The same order applies to the transmitted and the received word.
- R4: With `cpha`=1 the data-out line changes on edges 1, 3, 5 and so on, counted from 1 within the frame. Data-in is sampled on edges 2, 4, 6 and so on.
- R5: With `cpha`=0 the first data bit is on the data-out line from the cycle chip select falls. Data-in is sampled on odd edges, and data-out changes on even edges other than the last.
- R6: Outside a frame the serial clock rests at the level of `cpol`: low for 0, high for 1. It is back at that level after the last edge.
- R7: `done` rises H clocks after the last edge of a frame, in the same cycle that `rx_data` takes the received word. It then stays high until `flag_clr` is pulsed.
- R8: If a word is pending when a frame ends, the next frame starts in the cycle `done` rises. Chip select stays low between the two frames.
- R9: In a frame that does not follow straight on from another, chip select falls H clocks before the first edge. It stays low for H clocks after the last edge, then stays high for at least H clocks before the next frame.
- R10: Polarity, phase, width, order and divisor fields are captured when a frame starts. Changes made during the frame act only on later frames.
- R11: A `tx_wr` while a word is pending is dropped: that word is never sent. The write sets `wcol`, which `flag_clr` clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_data | input | 16 | Word to transmit |
| tx_wr | input | 1 | Write strobe for the transmit buffer |
| flag_clr | input | 1 | Clears `done` and `wcol` |
| cpol | input | 1 | Serial clock idle level |
| cpha | input | 1 | Clock phase select |
| wide | input | 1 | 1 = 16-bit frame, 0 = 8-bit frame |
| lsb_first | input | 1 | 1 = least significant bit first |
| pre_div | input | 3 | Linear divisor field |
| exp_div | input | 3 | Power-of-two divisor field |
| spi_miso | input | 1 | Serial data in |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_cs_n | output | 1 | Active-low chip select |
| rx_data | output | 16 | Last received word |
| done | output | 1 | Sticky frame-complete flag |
| wcol | output | 1 | Sticky write-collision flag |

## Verification
The embedded properties assume two things about the serial data-in line: it is valid only once chip select is low, and a well-behaved slave changes it only on the edges opposite the sampling edges. The bench slave model follows both rules. It drives data-in only on its own drive edges, or when chip select falls for phase 0, so the engine never samples a line that is changing.

The properties also assume the host leaves `cpol` alone in the cycle a frame is launched. The bench sets every configuration input at least one full cycle before its write strobe. The only mid-frame changes it makes are deliberate ones, applied after chip select has fallen, to probe the capture rule.

// File: rtl/spi_xfer_pkg.sv
`timescale 1ns/1ps
package spi_xfer_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_TRAIL = 2'd2,
    ST_GAP   = 2'd3
  } xfer_st_e;
endpackage

// File: rtl/spi_baud_gen.sv
`timescale 1ns/1ps
module spi_baud_gen #(
  parameter int PRE_W = 3,
  parameter int EXP_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PRE_W-1:0] pre,
  input  logic [EXP_W-1:0] expo,
  output logic             tick
);
  localparam int CNT_W = PRE_W + (1 << EXP_W);

  logic [CNT_W-1:0] cnt_q, cnt_d, half_w;

  always_comb begin
    half_w = (CNT_W'(pre) + CNT_W'(1)) << expo;
    tick   = run && (cnt_q == half_w - CNT_W'(1));
    cnt_d  = (!run || tick) ? '0 : cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_CNT_BELOW_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q < half_w)); // R1
endmodule

// File: rtl/spi_bit_path.sv
`timescale 1ns/1ps
module spi_bit_path #(
  parameter int MAX_W = 16,
  parameter int MIN_W = 8,
  localparam int IW   = $clog2(MAX_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             load_drive,
  input  logic [MAX_W-1:0] load_word,
  input  logic             lsbf,
  input  logic             wd,
  input  logic             drive_en,
  input  logic [IW-1:0]    drive_idx,
  input  logic             samp_en,
  input  logic [IW-1:0]    samp_idx,
  input  logic             miso,
  output logic             mosi,
  output logic [MAX_W-1:0] acc
);
  logic [MAX_W-1:0] tx_q, tx_d, acc_q, acc_d;
  logic             mosi_q, mosi_d;

  function automatic logic [IW-1:0] bitpos(input logic [IW-1:0] k,
                                           input logic lf, input logic w);
    logic [IW-1:0] hi;
    hi = w ? IW'(MAX_W - 1) : IW'(MIN_W - 1);
    return lf ? k : hi - k;
  endfunction

  always_comb begin
    tx_d   = tx_q;
    acc_d  = acc_q;
    mosi_d = mosi_q;
    if (load) begin
      tx_d  = load_word;
      acc_d = '0;
      if (load_drive) mosi_d = load_word[bitpos('0, lsbf, wd)];
    end else begin
      if (drive_en) mosi_d = tx_q[bitpos(drive_idx, lsbf, wd)];
      if (samp_en)  acc_d[bitpos(samp_idx, lsbf, wd)] = miso;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q   <= '0;
      acc_q  <= '0;
      mosi_q <= 1'b0;
    end else begin
      tx_q   <= tx_d;
      acc_q  <= acc_d;
      mosi_q <= mosi_d;
    end
  end

  assign mosi = mosi_q;
  assign acc  = acc_q;

  AST_SAMPLE_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    samp_en |-> (samp_idx <= (wd ? IW'(MAX_W - 1) : IW'(MIN_W - 1)))); // R2
  AST_MOSI_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(load || drive_en) |=> $stable(mosi_q)); // R4
endmodule

// File: rtl/spi_xfer_master.sv
`timescale 1ns/1ps
module spi_xfer_master #(
  parameter int MAX_W = 16,
  parameter int MIN_W = 8,
  parameter int PRE_W = 3,
  parameter int EXP_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [MAX_W-1:0] tx_data,
  input  logic             tx_wr,
  input  logic             flag_clr,
  input  logic             cpol,
  input  logic             cpha,
  input  logic             wide,
  input  logic             lsb_first,
  input  logic [PRE_W-1:0] pre_div,
  input  logic [EXP_W-1:0] exp_div,
  input  logic             spi_miso,
  output logic             spi_sck,
  output logic             spi_mosi,
  output logic             spi_cs_n,
  output logic [MAX_W-1:0] rx_data,
  output logic             done,
  output logic             wcol
);
  import spi_xfer_pkg::*;

  localparam int IW = $clog2(MAX_W);
  localparam int EW = $clog2(2 * MAX_W + 1);

  xfer_st_e         st_q, st_d;
  logic [EW-1:0]    edge_q, edge_d, n_edges, ne;
  logic             cs_n_q, cs_n_d, sck_q, sck_d;
  logic             pend_q, pend_d, done_q, done_d, wcol_q, wcol_d;
  logic [MAX_W-1:0] pend_w_q, pend_w_d, rx_q, rx_d, acc;
  logic             cpol_l, cpha_l, wide_l, lsb_l;
  logic             cpol_ld, cpha_ld, wide_ld, lsb_ld;
  logic [PRE_W-1:0] pre_l, pre_ld;
  logic [EXP_W-1:0] exp_l, exp_ld;
  logic             tick, start, edge_tick, odd;
  logic             drive_en, samp_en;
  logic [IW-1:0]    bidx, drive_idx;

  spi_baud_gen #(.PRE_W(PRE_W), .EXP_W(EXP_W)) u_baud (
    .clk(clk), .rst_n(rst_n), .run(st_q != ST_IDLE),
    .pre(pre_l), .expo(exp_l), .tick(tick)
  );

  always_comb begin
    n_edges   = wide_l ? EW'(2 * MAX_W) : EW'(2 * MIN_W);
    ne        = edge_q + EW'(1);
    odd       = ne[0];
    bidx      = IW'((ne - EW'(1)) >> 1);
    edge_tick = (st_q == ST_RUN) && tick;
    start     = pend_q && ((st_q == ST_IDLE) || ((st_q == ST_TRAIL) && tick));
    drive_en  = edge_tick && (cpha_l ? odd : (!odd && (ne != n_edges)));
    drive_idx = cpha_l ? bidx : bidx + IW'(1);
    samp_en   = edge_tick && (cpha_l ? !odd : odd);
  end

  spi_bit_path #(.MAX_W(MAX_W), .MIN_W(MIN_W)) u_bits (
    .clk(clk), .rst_n(rst_n),
    .load(start), .load_drive(start && !cpha), .load_word(pend_w_q),
    .lsbf(start ? lsb_first : lsb_l), .wd(start ? wide : wide_l),
    .drive_en(drive_en), .drive_idx(drive_idx),
    .samp_en(samp_en), .samp_idx(bidx),
    .miso(spi_miso), .mosi(spi_mosi), .acc(acc)
  );

  // next-state logic
  always_comb begin
    st_d = st_q;  edge_d = edge_q;  cs_n_d = cs_n_q;  sck_d = sck_q;
    pend_d = pend_q;  pend_w_d = pend_w_q;  rx_d = rx_q;
    done_d = done_q && !flag_clr;
    wcol_d = wcol_q && !flag_clr;
    cpol_ld = cpol_l; cpha_ld = cpha_l; wide_ld = wide_l; lsb_ld = lsb_l;
    pre_ld = pre_l; exp_ld = exp_l;

    unique case (st_q)
      ST_IDLE:  sck_d = cpol;
      ST_RUN:   if (tick) begin
                  sck_d  = ~sck_q;
                  edge_d = ne;
                  if (ne == n_edges) st_d = ST_TRAIL;
                end
      ST_TRAIL: if (tick) begin
                  done_d = 1'b1;
                  rx_d   = acc;
                  if (!pend_q) begin
                    st_d   = ST_GAP;
                    cs_n_d = 1'b1;
                  end
                end
      ST_GAP:   if (tick) st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase

    if (start) begin
      st_d = ST_RUN;  edge_d = '0;  cs_n_d = 1'b0;  pend_d = 1'b0;
      cpol_ld = cpol; cpha_ld = cpha; wide_ld = wide; lsb_ld = lsb_first;
      pre_ld = pre_div; exp_ld = exp_div;
    end

    if (tx_wr) begin
      if (pend_q) wcol_d = 1'b1;
      else begin
        pend_d   = 1'b1;
        pend_w_d = tx_data;
      end
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;  edge_q <= '0;  cs_n_q <= 1'b1;  sck_q <= 1'b0;
      pend_q <= 1'b0;  pend_w_q <= '0;  rx_q <= '0;
      done_q <= 1'b0;  wcol_q <= 1'b0;
      cpol_l <= 1'b0;  cpha_l <= 1'b0;  wide_l <= 1'b0;  lsb_l <= 1'b0;
      pre_l <= '0;  exp_l <= '0;
    end else begin
      st_q <= st_d;  edge_q <= edge_d;  cs_n_q <= cs_n_d;  sck_q <= sck_d;
      pend_q <= pend_d;  pend_w_q <= pend_w_d;  rx_q <= rx_d;
      done_q <= done_d;  wcol_q <= wcol_d;
      cpol_l <= cpol_ld;  cpha_l <= cpha_ld;  wide_l <= wide_ld;  lsb_l <= lsb_ld;
      pre_l <= pre_ld;  exp_l <= exp_ld;
    end
  end

  assign spi_sck  = sck_q;
  assign spi_cs_n = cs_n_q;
  assign rx_data  = rx_q;
  assign done     = done_q;
  assign wcol     = wcol_q;

  AST_SCK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q != ST_IDLE) && !tick) |=> $stable(sck_q)); // R1
  AST_EDGE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RUN) |-> (edge_q < n_edges)); // R2
  AST_REST_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_TRAIL) || (st_q == ST_GAP)) |-> (sck_q == cpol_l)); // R6
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !flag_clr) |=> done_q); // R7
  AST_CS_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_RUN) || (st_q == ST_TRAIL)) |-> !cs_n_q); // R9
  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RUN) |=> ($stable(lsb_l) && $stable(wide_l) && $stable(pre_l))); // R10
  AST_WCOL_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_wr && pend_q) |=> wcol_q); // R11
endmodule

// File: tb/spi_xfer_master_tb.sv
`timescale 1ns/1ps
module spi_xfer_master_tb;
  logic        clk, rst_n;
  logic [15:0] tx_data;
  logic        tx_wr, flag_clr, cpol, cpha, wide, lsb_first;
  logic [2:0]  pre_div, exp_div;
  logic        spi_miso;
  logic        spi_sck, spi_mosi, spi_cs_n, done, wcol;
  logic [15:0] rx_data;

  int n_checks = 0;
  int n_errors = 0;
  int cyc = 0;

  spi_xfer_master u_dut (
    .clk(clk), .rst_n(rst_n), .tx_data(tx_data), .tx_wr(tx_wr),
    .flag_clr(flag_clr), .cpol(cpol), .cpha(cpha), .wide(wide),
    .lsb_first(lsb_first), .pre_div(pre_div), .exp_div(exp_div),
    .spi_miso(spi_miso), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
    .spi_cs_n(spi_cs_n), .rx_data(rx_data), .done(done), .wcol(wcol)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // slave model state
  bit          armed = 0;
  bit          s_cpha, s_lsb;
  int          s_nbits = 8;
  logic [15:0] s_tx, s_rx;
  int          s_edge, s_total, s_rises;
  logic [15:0] cap [0:63];
  int          ncap = 0;
  logic        prev_cs = 1'b1, prev_sck = 1'b0;
  time         t_fall, t_rise, t_e1, t_e2, t_last, t_done;

  function automatic int spos(input int k);
    return s_lsb ? k : s_nbits - 1 - k;
  endfunction

  always @(spi_sck or spi_cs_n) begin
    if (armed) begin
      if (prev_cs && !spi_cs_n) begin
        s_edge = 0; s_rx = '0; t_fall = $time;
        if (!s_cpha) spi_miso = s_tx[spos(0)];
      end else if (!prev_cs && spi_cs_n) begin
        s_rises++; t_rise = $time;
      end else if (!spi_cs_n && (spi_sck !== prev_sck)) begin
        int k;
        bit o;
        s_edge++; s_total++;
        if (s_edge == 1) t_e1 = $time;
        if (s_edge == 2) t_e2 = $time;
        t_last = $time;
        o = (s_edge % 2) == 1;
        k = (s_edge - 1) / 2;
        if (s_cpha ? !o : o) s_rx[spos(k)] = spi_mosi;
        if (s_cpha ? o : (!o && s_edge < 2 * s_nbits))
          spi_miso = s_tx[spos(s_cpha ? k : k + 1)];
        if (s_edge == 2 * s_nbits) begin
          cap[ncap] = s_rx; ncap++;
          s_edge = 0; s_rx = '0;
          if (!s_cpha) spi_miso = s_tx[spos(0)];
        end
      end
    end
    prev_cs = spi_cs_n;
    prev_sck = spi_sck;
  end

  always @(posedge done) t_done = $time;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic write_word(input logic [15:0] w);
    @(negedge clk); tx_wr = 1'b1; tx_data = w;
    @(negedge clk); tx_wr = 1'b0;
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
  endtask

  task automatic clear_flags();
    @(negedge clk); flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0;
  endtask

  task automatic setup(input bit cp, ph, wd, lf, input int p, s, input logic [15:0] sw);
    @(negedge clk);
    cpol = cp; cpha = ph; wide = wd; lsb_first = lf;
    pre_div = 3'(p); exp_div = 3'(s);
    s_cpha = ph; s_lsb = lf; s_nbits = wd ? 16 : 8; s_tx = sw; s_total = 0;
    @(negedge clk);
  endtask

  task automatic run_frame(input bit cp, ph, wd, lf, input int p, s,
                           input logic [15:0] tw, sw, input bit perturb);
    int h, n, c0;
    logic [15:0] m;
    h = (p + 1) << s; n = wd ? 16 : 8; m = wd ? 16'hFFFF : 16'h00FF;
    setup(cp, ph, wd, lf, p, s, sw);
    c0 = ncap;
    write_word(tw);
    if (perturb) begin
      while (spi_cs_n) @(negedge clk);
      lsb_first = ~lf; wide = ~wd; cpha = ~ph;
      pre_div = 3'(p + 2); exp_div = 3'(s + 1);
    end
    wait_done();
    chk(ncap == c0 + 1, "R2 one frame seen", ncap - c0, 1);
    chk(s_total == 2 * n, perturb ? "R10 R2 edge count" : "R2 edge count", s_total, 2 * n);
    chk(cap[c0] == (tw & m), ph ? "R4 R3 slave capture cpha1" : "R5 R3 slave capture cpha0",
        cap[c0], tw & m);
    chk(rx_data == (sw & m), perturb ? "R10 R3 rx word" : "R3 R7 rx word", rx_data, sw & m);
    chk(t_e1 - t_fall == h * 20, "R9 lead time", t_e1 - t_fall, h * 20);
    chk(t_e2 - t_e1 == h * 20, perturb ? "R10 R1 half period" : "R1 half period",
        t_e2 - t_e1, h * 20);
    chk(t_done - t_last == h * 20, "R7 flag lag", t_done - t_last, h * 20);
    chk(t_rise - t_last == h * 20, "R9 trail time", t_rise - t_last, h * 20);
    chk(spi_sck == cp, "R6 rest level", spi_sck, cp);
    clear_flags();
    chk(done == 1'b0, "R7 flag cleared", done, 0);
    repeat (h + 2) @(negedge clk);
  endtask

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc == 190000) begin
      n_errors++; n_checks++;
      $display("FAIL watchdog actual=%0d expected=<190000", cyc);
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] tw, sw;
    int c0, r0;
    rst_n = 1'b0; tx_data = '0; tx_wr = 0; flag_clr = 0;
    cpol = 0; cpha = 0; wide = 0; lsb_first = 0; pre_div = 0; exp_div = 0;
    spi_miso = 0; s_tx = '0; s_cpha = 0; s_lsb = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(spi_cs_n == 1'b1, "R9 reset select high", spi_cs_n, 1);
    chk(done == 1'b0, "R7 reset done", done, 0);
    chk(wcol == 1'b0, "R11 reset wcol", wcol, 0);
    chk(rx_data == 16'h0, "R7 reset rx", rx_data, 0);
    chk(spi_sck == 1'b0, "R6 reset rest level", spi_sck, 0);
    armed = 1;
    cpol = 1'b1;
    repeat (2) @(negedge clk);
    chk(spi_sck == 1'b1, "R6 idle follows cpol", spi_sck, 1);

    // all modes at two divisor settings
    for (int d = 0; d < 2; d++) begin
      for (int md = 0; md < 16; md++) begin
        tw = 16'hA5C3 ^ 16'(md * 16'h1357) ^ 16'(d * 16'h0F0F);
        sw = {tw[6:0], tw[15:7]} ^ 16'h6699;
        run_frame(md[0], md[1], md[2], md[3], d, d, tw, sw, 0);
      end
    end

    // divisor sweep
    for (int p = 0; p < 8; p++) begin
      for (int s = 0; s < 4; s++) begin
        tw = 16'(p * 37 + s * 91 + 5);
        sw = 16'(~(p * 53 + s * 17));
        run_frame(s[0], p[0], 1'b0, p[1], p, s, tw, sw, 0);
      end
    end
    run_frame(1'b0, 1'b1, 1'b0, 1'b0, 0, 7, 16'h00B4, 16'h004B, 0);
    run_frame(1'b1, 1'b0, 1'b0, 1'b1, 7, 7, 16'h0093, 16'h0061, 0);

    // R10: inputs change mid-frame
    run_frame(1'b0, 1'b1, 1'b1, 1'b0, 1, 1, 16'hC0DE, 16'h1E55, 1);
    run_frame(1'b1, 1'b0, 1'b0, 1'b1, 0, 2, 16'h005A, 16'h00E7, 1);

    // R8 / R11: back-to-back and collision
    setup(1'b0, 1'b0, 1'b1, 1'b1, 1, 0, 16'h3C5A);
    c0 = ncap; r0 = s_rises;
    write_word(16'h1234);
    while (spi_cs_n) @(negedge clk);
    write_word(16'hBEEF);
    write_word(16'hDEAD);
    chk(wcol == 1'b1, "R11 collision flag", wcol, 1);
    wait_done();
    chk(rx_data == 16'h3C5A, "R8 first rx", rx_data, 16'h3C5A);
    chk(spi_cs_n == 1'b0, "R8 select held low", spi_cs_n, 0);
    chk(s_rises == r0, "R8 no select release", s_rises - r0, 0);
    clear_flags();
    chk(wcol == 1'b0, "R11 collision cleared", wcol, 0);
    wait_done();
    chk(cap[c0] == 16'h1234, "R8 first word", cap[c0], 16'h1234);
    chk(cap[c0 + 1] == 16'hBEEF, "R8 chained word", cap[c0 + 1], 16'hBEEF);
    clear_flags();
    repeat (20) @(negedge clk);
    chk(ncap == c0 + 2, "R11 dropped word not sent", ncap - c0, 2);
    chk(spi_cs_n == 1'b1, "R11 select idle after chain", spi_cs_n, 1);

    // R9: idle gap between separate frames
    setup(1'b1, 1'b1, 1'b0, 1'b0, 3, 0, 16'h00C6);
    c0 = ncap;
    write_word(16'h0071);
    wait_done();
    write_word(16'h008E);
    r0 = int'(t_rise);
    while (spi_cs_n) @(negedge clk);
    chk(t_fall - time'(r0) >= 80, "R9 idle gap", t_fall - time'(r0), 80);
    clear_flags();
    wait_done();
    chk(cap[c0 + 1] == 16'h008E, "R9 second separate frame", cap[c0 + 1], 16'h008E);
    clear_flags();
    repeat (8) @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end
endmodule